// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Priority Selector

This block sits between the interrupt state storage of a multi-core interrupt controller and the request lines of its processors. For every CPU target it looks at all interrupt sources that are both enabled and pending for that CPU, picks the most urgent one, and reports its number as the highest-pending ID. It raises the CPU's request line only when that candidate also preempts the work the CPU is already doing.

Each CPU has an 8-bit priority mask register held inside the block and loaded through a per-CPU load strobe. The running priority of each CPU comes from the acknowledge and completion logic outside the block, as a 9-bit value where 0x100 means idle. The sources below 32 carry a separate priority for each CPU. The sources from 32 upward carry one priority that all CPUs share. A balanced comparison tree replaces a serial scan, and both outputs are registered.

Top module: `prio_sel_top`

## Requirements
- R1: A smaller priority value is more urgent. The reported ID is the qualifying source with the smallest priority value.
- R2: When several qualifying sources share the smallest priority value, the one with the lowest source number is reported.
- R3: A source counts only when its enable bit and its pending bit for that CPU are both 1. When no source counts, the highest-pending ID is 1023 and the request is low.
- R4: A candidate is reported only if its priority is less than or equal to the CPU's mask. Otherwise the ID is 1023 and the request is low.
- R5: The request line of a CPU is high only when the reported candidate's priority is strictly below that CPU's running priority. A running priority of 0x100 means idle.
- R6: While the global enable or the CPU's interface enable is 0, that CPU's request is low and its ID is 1023. Other CPUs are not affected.
- R7: Sources 0 to 31 use a per-CPU priority. Byte (c*32+s) of banked_prio_i is the priority of source s for CPU c.
- R8: Sources 32 and up use one shared priority for all CPUs. Byte (s-32) of shared_prio_i is the priority of source s.
- R9: After reset, every request is low, every ID is 1023, and every mask is 0xF0.
- R10: Outputs are registered. A change on the inputs shows at the outputs after exactly one rising clock edge.
- R11: A load strobe on mask_load_i[c] writes mask_value_i into CPU c's mask only. The new mask governs the outputs computed at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en_i | input | 1 | Global enable |
| cpu_if_en_i | input | NUM_CPU | Per-CPU interface enable |
| src_en_i | input | NUM_SRC | Per-source enable |
| src_pend_i | input | NUM_CPU*NUM_SRC | Pending bits, bit c*NUM_SRC+s is source s for CPU c |
| banked_prio_i | input | NUM_CPU*32*8 | Per-CPU priorities of sources 0..31 |
| shared_prio_i | input | (NUM_SRC-32)*8 | Shared priorities of sources 32 and up |
| mask_load_i | input | NUM_CPU | Per-CPU mask load strobe |
| mask_value_i | input | 8 | Value loaded into a mask |
| run_prio_i | input | NUM_CPU*9 | Running priority per CPU, 0x100 means idle |
| irq_o | output | NUM_CPU | Registered request line per CPU |
| hp_id_o | output | NUM_CPU*10 | Registered highest-pending ID per CPU |

## Verification
The bench targets the tie rule. A design that let the later or the higher-numbered source win on equal priority would report the wrong ID. It also probes the boundary cases: a priority equal to the mask, which must still qualify, and a priority equal to the running priority, which must not raise the request. Getting either comparison wrong shows up as a spurious ID or an extra request. Further checks cover per-CPU banking against shared priorities, gating by each of the two enables, and the reset mask of 0xF0. A mask or priority routed to the wrong CPU shows up as one CPU reacting to another's settings.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;
    localparam int PRIO_W     = 8;
    localparam int ID_W       = 10;
    localparam int BANKED_SRC = 32;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W:0]   IDLE_PRIO   = 9'h100;
    localparam logic [PRIO_W-1:0] MASK_RST    = 8'hF0;

    typedef struct packed {
        logic [PRIO_W:0]   prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // lo holds the lower source numbers; hi wins only on a strictly smaller value
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        return (hi.prio < lo.prio) ? hi : lo;
    endfunction
endpackage

// File: rtl/prio_sel_tree.sv
module prio_sel_tree
    import prio_sel_pkg::*;
#(
    parameter int LEAVES = 64   // power of two keeps heap order equal to source order
) (
    input  cand_t leaf_i [LEAVES],
    output cand_t win_o
);
    localparam int NODES = 2 * LEAVES - 1;

    cand_t node [NODES];

    genvar k;
    generate
        for (k = 0; k < LEAVES; k++) begin : g_leaf
            assign node[LEAVES-1+k] = leaf_i[k];
        end
        for (k = 0; k < LEAVES - 1; k++) begin : g_node
            assign node[k] = pick(node[2*k+1], node[2*k+2]);
        end
    endgenerate

    assign win_o = node[0];
endmodule

// File: rtl/prio_sel_cpu.sv
module prio_sel_cpu
    import prio_sel_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_i,
    input  logic [NUM_SRC-1:0]  src_en_i,
    input  logic [NUM_SRC-1:0]  src_pend_i,
    input  logic [PRIO_W-1:0]   prio_i [NUM_SRC],
    input  logic [PRIO_W-1:0]   mask_i,
    input  logic [PRIO_W:0]     run_prio_i,
    output logic                irq_o,
    output logic [ID_W-1:0]     hp_id_o
);
    cand_t leaf [NUM_SRC];
    cand_t win;
    logic  qualify;
    logic  irq_d;
    logic [ID_W-1:0] id_d;

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_cand
            assign leaf[k].prio = (src_en_i[k] && src_pend_i[k]) ? {1'b0, prio_i[k]} : IDLE_PRIO;
            assign leaf[k].id   = ID_W'(k);
        end
    endgenerate

    prio_sel_tree #(.LEAVES(NUM_SRC)) u_tree (
        .leaf_i (leaf),
        .win_o  (win)
    );

    always_comb begin
        qualify = gate_i && (win.prio <= {1'b0, mask_i});
        id_d    = qualify ? win.id : SPURIOUS_ID;
        irq_d   = qualify && (win.prio < run_prio_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o   <= 1'b0;
            hp_id_o <= SPURIOUS_ID;
        end else begin
            irq_o   <= irq_d;
            hp_id_o <= id_d;
        end
    end

    // R6
    gate_low_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_i |=> (!irq_o && hp_id_o == SPURIOUS_ID));
    // R5
    run_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_prio_i == '0) |=> !irq_o);
    // R3
    irq_has_id_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (hp_id_o != SPURIOUS_ID));

    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_tree_chk
            // R1
            min_prio_chk: assert property (@(posedge clk) disable iff (rst)
                (leaf[k].prio != IDLE_PRIO) |-> (win.prio <= leaf[k].prio));
            // R2
            tie_low_chk: assert property (@(posedge clk) disable iff (rst)
                (leaf[k].prio == win.prio && win.prio != IDLE_PRIO) |-> (win.id <= ID_W'(k)));
        end
    endgenerate
endmodule

// File: rtl/prio_sel_top.sv
module prio_sel_top
    import prio_sel_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                dist_en_i,
    input  logic [NUM_CPU-1:0]                  cpu_if_en_i,
    input  logic [NUM_SRC-1:0]                  src_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]          src_pend_i,
    input  logic [NUM_CPU*BANKED_SRC*PRIO_W-1:0] banked_prio_i,
    input  logic [(NUM_SRC-BANKED_SRC)*PRIO_W-1:0] shared_prio_i,
    input  logic [NUM_CPU-1:0]                  mask_load_i,
    input  logic [PRIO_W-1:0]                   mask_value_i,
    input  logic [NUM_CPU*(PRIO_W+1)-1:0]       run_prio_i,
    output logic [NUM_CPU-1:0]                  irq_o,
    output logic [NUM_CPU*ID_W-1:0]             hp_id_o
);
    localparam int RUN_W = PRIO_W + 1;

    logic [PRIO_W-1:0] mask_q [NUM_CPU];

    genvar c, k;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic [PRIO_W-1:0] eff_prio [NUM_SRC];

            for (k = 0; k < NUM_SRC; k++) begin : g_prio
                if (k < BANKED_SRC) begin : g_bank
                    assign eff_prio[k] = banked_prio_i[(c*BANKED_SRC+k)*PRIO_W +: PRIO_W];
                end else begin : g_share
                    assign eff_prio[k] = shared_prio_i[(k-BANKED_SRC)*PRIO_W +: PRIO_W];
                end
            end

            always_ff @(posedge clk) begin
                if (rst)                 mask_q[c] <= MASK_RST;
                else if (mask_load_i[c]) mask_q[c] <= mask_value_i;
            end

            prio_sel_cpu #(.NUM_SRC(NUM_SRC)) u_cpu (
                .clk        (clk),
                .rst        (rst),
                .gate_i     (dist_en_i && cpu_if_en_i[c]),
                .src_en_i   (src_en_i),
                .src_pend_i (src_pend_i[c*NUM_SRC +: NUM_SRC]),
                .prio_i     (eff_prio),
                .mask_i     (mask_q[c]),
                .run_prio_i (run_prio_i[c*RUN_W +: RUN_W]),
                .irq_o      (irq_o[c]),
                .hp_id_o    (hp_id_o[c*ID_W +: ID_W])
            );

            // R9
            mask_rst_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (mask_q[c] == MASK_RST));
            // R11
            mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !mask_load_i[c] |=> $stable(mask_q[c]));
        end
    endgenerate
endmodule

// File: tb/tb_prio_sel_top.sv
module tb_prio_sel_top;
    localparam int NSRC = 64;
    localparam int NCPU = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dist_en = 1'b0;
    logic [NCPU-1:0]        cpu_en = '0;
    logic [NSRC-1:0]        en = '0;
    logic [NCPU*NSRC-1:0]   pend = '0;
    logic [NCPU*32*8-1:0]   pb = '0;
    logic [(NSRC-32)*8-1:0] ps = '0;
    logic [NCPU-1:0]        mload = '0;
    logic [7:0]             mval = '0;
    logic [NCPU*9-1:0]      run = {NCPU{9'h100}};
    logic [NCPU-1:0]        irq;
    logic [NCPU*10-1:0]     hp;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prio_sel_top #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) dut (
        .clk(clk), .rst(rst), .dist_en_i(dist_en), .cpu_if_en_i(cpu_en),
        .src_en_i(en), .src_pend_i(pend), .banked_prio_i(pb), .shared_prio_i(ps),
        .mask_load_i(mload), .mask_value_i(mval), .run_prio_i(run),
        .irq_o(irq), .hp_id_o(hp)
    );

    // {a_src, a_prio, b_src, b_prio, run, exp_id, exp_irq}, all on CPU 0 with mask 0xFF
    localparam logic [47:0] VEC [7] = '{
        {6'd5,  8'h40, 6'd40, 8'h20, 9'h100, 10'd40, 1'b1},  // R1
        {6'd3,  8'h30, 6'd9,  8'h30, 9'h100, 10'd3,  1'b1},  // R2
        {6'd50, 8'h10, 6'd33, 8'h10, 9'h100, 10'd33, 1'b1},  // R2
        {6'd7,  8'h80, 6'd60, 8'h90, 9'h080, 10'd7,  1'b0},  // R5 equal
        {6'd7,  8'h80, 6'd60, 8'h90, 9'h081, 10'd7,  1'b1},  // R5 below
        {6'd0,  8'h00, 6'd63, 8'hFF, 9'h000, 10'd0,  1'b0},  // R5 zero
        {6'd63, 8'hFF, 6'd62, 8'hFF, 9'h100, 10'd62, 1'b1}   // R4 mask edge
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int c, input int s, input logic [7:0] v);
        if (s < 32) pb[(c*32+s)*8 +: 8] = v;
        else        ps[(s-32)*8 +: 8] = v;
    endtask

    function automatic logic [9:0] hid(input int c);
        return hp[c*10 +: 10];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCPU; c++) begin
            chk("R9 reset irq", irq[c], 0);
            chk("R9 reset id", hid(c), 1023);
        end
        rst = 0;
        dist_en = 1; cpu_en = '1; en = '1;
        // R9 reset mask 0xF0: priority 0xF0 qualifies
        set_prio(0, 4, 8'hF0); pend[4] = 1;
        step();
        chk("R9 mask F0 id", hid(0), 4);
        chk("R9 mask F0 irq", irq[0], 1);
        set_prio(0, 4, 8'hF1);
        step();
        chk("R4 above mask id", hid(0), 1023);
        chk("R4 above mask irq", irq[0], 0);
        // R3 enable and pending both needed
        pend = '0; set_prio(0, 20, 8'h10); pend[20] = 1; en[20] = 0;
        step();
        chk("R3 disabled id", hid(0), 1023);
        chk("R3 disabled irq", irq[0], 0);
        en[20] = 1;
        step();
        chk("R3 enabled id", hid(0), 20);
        pend = '0;
        step();
        chk("R3 none id", hid(0), 1023);
        // open CPU 0 mask
        mload[0] = 1; mval = 8'hFF; step(); mload = '0;
        for (int i = 0; i < 7; i++) begin
            logic [47:0] v;
            v = VEC[i];
            pend = '0;
            set_prio(0, int'(v[47:42]), v[41:34]);
            set_prio(0, int'(v[33:28]), v[27:20]);
            pend[v[47:42]] = 1; pend[v[33:28]] = 1;
            run[8:0] = v[19:11];
            step();
            chk($sformatf("R1 R2 R4 R5 vec%0d id", i), hid(0), v[10:1]);
            chk($sformatf("R5 vec%0d irq", i), irq[0], v[0]);
        end
        run = {NCPU{9'h100}};
        // R6 gating
        pend = '0; set_prio(0, 12, 8'h10); set_prio(1, 12, 8'h10);
        pend[12] = 1; pend[NSRC+12] = 1;
        dist_en = 0;
        step();
        chk("R6 global off id", hid(0), 1023);
        chk("R6 global off irq", irq[0], 0);
        dist_en = 1; cpu_en[0] = 0;
        step();
        chk("R6 cpu off id", hid(0), 1023);
        chk("R6 cpu off irq", irq[0], 0);
        chk("R6 other cpu id", hid(1), 12);
        chk("R6 other cpu irq", irq[1], 1);
        cpu_en = '1;
        // R7 banked priorities
        pend = '0; set_prio(0, 10, 8'h10); set_prio(1, 10, 8'hF8);
        pend[10] = 1; pend[NSRC+10] = 1;
        step();
        chk("R7 cpu0 id", hid(0), 10);
        chk("R7 cpu1 id", hid(1), 1023);
        // R8 shared priority
        pend = '0; set_prio(0, 45, 8'h50);
        pend[2*NSRC+45] = 1; pend[3*NSRC+45] = 1;
        step();
        chk("R8 cpu2 id", hid(2), 45);
        chk("R8 cpu3 id", hid(3), 45);
        chk("R8 cpu0 id", hid(0), 1023);
        // R10 one edge latency
        pend = '0; step();
        set_prio(0, 21, 8'h05); pend[21] = 1;
        #1;
        chk("R10 before edge", hid(0), 1023);
        step();
        chk("R10 after edge", hid(0), 21);
        // R11 per-CPU mask load
        pend = '0; set_prio(0, 40, 8'h30); pend[40] = 1; pend[NSRC+40] = 1;
        step();
        chk("R11 before load", hid(1), 40);
        mload[1] = 1; mval = 8'h20;
        step();
        mload = '0;
        step();
        chk("R11 cpu1 masked", hid(1), 1023);
        chk("R11 cpu0 kept", hid(0), 40);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule